// File: doc/BRIEF.md
# Dual-Channel Bus-Master IDE Register Block

This block holds the byte-wide control registers of a two-channel IDE bus-master controller and combines the interrupt requests of both channels into one interrupt line. Software reaches it through a 16-byte I/O window. Each channel owns an 8-byte slice. The lower four bytes of a slice are control registers. The upper four bytes belong to a descriptor-pointer store that lives outside this block.

In each slice the low two address bits select the register: command, the mode register (one copy shared by both channels), status, and a per-channel timing byte. A command write is passed on to an external DMA engine as a one-cycle strobe that carries the written byte. The shared mode register keeps one interrupt flag per channel, copied from that channel's request level, and one mask bit per channel that software can write. The interrupt output is high while any channel has its flag set and its mask clear. Status bits behave in three ways: some can be written, some are write-1-to-clear and are set by DMA engine events, and one mirrors the engine's busy level.

Only single-byte accesses are valid. A wider read returns all ones for its width. A wider write is ignored. Read data appears one cycle after the access.

Top module: `dcbm_regs`

## Requirements
- R1: After synchronous reset, the command, status, timing and mode registers are zero, `irq_out` is low and `cmd_stb` is 0.
- R2: A byte read at address A returns its value in `rdata[7:0]` (upper bits zero) in the cycle after the access. A[3] selects the channel and A[1:0] selects the register: 0 command, 1 mode (the same register at offsets 1 and 9), 2 status, 3 timing (a separate byte per channel). Reads change no register.
- R3: `acc_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. A read with size 1 returns 32'h0000FFFF and a read with size 2 or 3 returns 32'hFFFFFFFF. A write with a nonzero size changes no register and raises no strobe.
- R4: A byte write to the mode register changes only bit 4 (mask for channel 0) and bit 5 (mask for channel 1). All other mode bits keep their values.
- R5: Mode bit 2+c (c = channel) follows `irq_req[c]`, with one clock of delay. It is set while the request is high and clear while it is low.
- R6: `irq_out` is high exactly when (mode bit 2 and not bit 4) or (mode bit 3 and not bit 5). It follows the mode register with no further delay, so it changes in the same cycle that a mask write takes effect.
- R7: A status write loads bits 5 and 6 from the written byte. Bits 3, 4 and 7 always read as zero.
- R8: Status bit 1 is set by a pulse on `err_set[c]` and bit 2 by a pulse on `done_set[c]`. A status write clears each of these bits where the written bit is 1. If a set and a clear hit the same bit in the same cycle, the bit ends up set.
- R9: Status bit 0 mirrors `dma_busy[c]` with one clock of delay. A status write never changes it.
- R10: A byte write to command offset 0 or 8 stores the byte for read-back. In the next cycle it pulses `cmd_stb[c]` for exactly one cycle, with `cmd_byte` equal to the written byte.
- R11: The descriptor-pointer bytes (A[2] = 1) read as 8'h00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request for this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset in the window |
| acc_size | input | 2 | Access width code |
| acc_wdata | input | 32 | Write data (byte in bits 7:0) |
| irq_req | input | 2 | Per-channel interrupt request levels |
| dma_busy | input | 2 | Per-channel DMA busy level |
| err_set | input | 2 | Per-channel error event pulse |
| done_set | input | 2 | Per-channel interrupt event pulse |
| rdata | output | 32 | Registered read data |
| cmd_stb | output | 2 | Per-channel command-write strobe |
| cmd_byte | output | 8 | Byte carried by the command strobe |
| irq_out | output | 1 | Combined active-high interrupt |

## Verification
The interrupt combiner is driven through each flag and mask combination: one channel requesting with no mask, the same request masked, both channels requesting with one mask or both masks set, and requests dropping while masks are clear. Together these show that the flags and masks are kept per channel and combined by OR. The status tests clear a bit in the same cycle a hardware event sets it, hold the busy level across a write, and write all ones and then zero. These tell the writable, write-1-to-clear and mirrored bits apart. Wide reads and writes, writes to the pointer bytes, and read-back at both channel offsets show that the address decode and the width filter reject what they should and touch nothing else.

// File: rtl/dcbm_pkg.sv
package dcbm_pkg;
    localparam int NCH     = 2;
    localparam int AW      = 4;
    localparam int DW      = 32;
    localparam int BW      = 8;
    localparam int FLAG_LO = 2;
    localparam int MASK_LO = 4;
    localparam logic [BW-1:0] STAT_RW_M  = 8'h60;
    localparam logic [BW-1:0] STAT_W1C_M = 8'h06;

    typedef enum logic [1:0] {
        SEL_CMD  = 2'd0,
        SEL_MODE = 2'd1,
        SEL_STAT = 2'd2,
        SEL_TIM  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic          rd;
        logic          wr;
        logic          byte_ok;
        logic          ptr;
        logic          ch;
        reg_sel_e      sel;
        logic [BW-1:0] wbyte;
    } acc_dec_t;

    function automatic logic [DW-1:0] wide_ones(input logic [1:0] sz);
        return (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    endfunction

    function automatic logic [BW-1:0] stat_merge(input logic [BW-1:0] old,
                                                 input logic [BW-1:0] w);
        return (w & STAT_RW_M) | (old & 8'h01) | (old & ~w & STAT_W1C_M);
    endfunction
endpackage

// File: rtl/dcbm_chan.sv
module dcbm_chan
    import dcbm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_cmd,
    input  logic          wr_stat,
    input  logic          wr_tim,
    input  logic [BW-1:0] wbyte,
    input  logic          busy,
    input  logic          err_ev,
    input  logic          done_ev,
    output logic [BW-1:0] cmd_q,
    output logic [BW-1:0] stat_q,
    output logic [BW-1:0] tim_q,
    output logic          stb_q
);
    logic [BW-1:0] stat_d;

    always_comb begin
        stat_d    = wr_stat ? stat_merge(stat_q, wbyte) : stat_q;
        stat_d[0] = busy;
        stat_d[1] = stat_d[1] | err_ev;
        stat_d[2] = stat_d[2] | done_ev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            stat_q <= '0;
            tim_q  <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q  <= wr_cmd;
            stat_q <= stat_d;
            if (wr_cmd) cmd_q <= wbyte;
            if (wr_tim) tim_q <= wbyte;
        end
    end
endmodule

// File: rtl/dcbm_mode.sv
module dcbm_mode
    import dcbm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_mode,
    input  logic [BW-1:0]  wbyte,
    input  logic [NCH-1:0] req,
    output logic [BW-1:0]  mode_q,
    output logic           irq
);
    logic [BW-1:0]  mode_d;
    logic [NCH-1:0] live;

    always_comb begin
        mode_d = mode_q;
        for (int c = 0; c < NCH; c++) begin
            mode_d[FLAG_LO+c] = req[c];
            if (wr_mode) mode_d[MASK_LO+c] = wbyte[MASK_LO+c];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_live
        assign live[c] = mode_q[FLAG_LO+c] & ~mode_q[MASK_LO+c];
    end

    assign irq = |live;
endmodule

// File: rtl/dcbm_regs.sv
module dcbm_regs
    import dcbm_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           acc_valid,
    input  logic           acc_write,
    input  logic [AW-1:0]  acc_addr,
    input  logic [1:0]     acc_size,
    input  logic [DW-1:0]  acc_wdata,
    input  logic [NCH-1:0] irq_req,
    input  logic [NCH-1:0] dma_busy,
    input  logic [NCH-1:0] err_set,
    input  logic [NCH-1:0] done_set,
    output logic [DW-1:0]  rdata,
    output logic [NCH-1:0] cmd_stb,
    output logic [BW-1:0]  cmd_byte,
    output logic           irq_out
);
    acc_dec_t               dec;
    logic [NCH-1:0]         wr_cmd, wr_stat, wr_tim;
    logic                   wr_mode;
    logic [NCH-1:0][BW-1:0] cmd_q, stat_q, tim_q;
    logic [BW-1:0]          mode_q;
    logic [BW-1:0]          rbyte;
    logic [DW-1:0]          rdata_q;

    always_comb begin
        dec.rd      = acc_valid & ~acc_write;
        dec.wr      = acc_valid & acc_write;
        dec.byte_ok = (acc_size == 2'd0);
        dec.ptr     = acc_addr[2];
        dec.ch      = acc_addr[3];
        dec.sel     = reg_sel_e'(acc_addr[1:0]);
        dec.wbyte   = acc_wdata[BW-1:0];
    end

    assign wr_mode = dec.wr & dec.byte_ok & ~dec.ptr & (dec.sel == SEL_MODE);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit        = dec.wr & dec.byte_ok & ~dec.ptr & (dec.ch == c[0]);
        assign wr_cmd[c]  = hit & (dec.sel == SEL_CMD);
        assign wr_stat[c] = hit & (dec.sel == SEL_STAT);
        assign wr_tim[c]  = hit & (dec.sel == SEL_TIM);

        dcbm_chan u_chan (
            .clk    (clk),
            .rst    (rst),
            .wr_cmd (wr_cmd[c]),
            .wr_stat(wr_stat[c]),
            .wr_tim (wr_tim[c]),
            .wbyte  (dec.wbyte),
            .busy   (dma_busy[c]),
            .err_ev (err_set[c]),
            .done_ev(done_set[c]),
            .cmd_q  (cmd_q[c]),
            .stat_q (stat_q[c]),
            .tim_q  (tim_q[c]),
            .stb_q  (cmd_stb[c])
        );
    end

    dcbm_mode u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr_mode(wr_mode),
        .wbyte  (dec.wbyte),
        .req    (irq_req),
        .mode_q (mode_q),
        .irq    (irq_out)
    );

    always_comb begin
        rbyte = '0;
        if (!dec.ptr) begin
            unique case (dec.sel)
                SEL_CMD:  rbyte = cmd_q[dec.ch];
                SEL_MODE: rbyte = mode_q;
                SEL_STAT: rbyte = stat_q[dec.ch];
                SEL_TIM:  rbyte = tim_q[dec.ch];
                default:  rbyte = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (dec.rd) rdata_q <= dec.byte_ok ? {{(DW-BW){1'b0}}, rbyte}
                                                : wide_ones(acc_size);
    end

    assign rdata    = rdata_q;
    assign cmd_byte = cmd_stb[1] ? cmd_q[1] : cmd_q[0];
endmodule

// File: rtl/dcbm_regs_chk.sv
module dcbm_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [3:0]  acc_addr,
    input logic [1:0]  acc_size,
    input logic [31:0] acc_wdata,
    input logic [1:0]  irq_req,
    input logic [1:0]  dma_busy,
    input logic [1:0]  err_set,
    input logic [31:0] rdata,
    input logic [1:0]  cmd_stb,
    input logic [7:0]  cmd_byte,
    input logic        irq_out,
    input logic [7:0]  mode_q,
    input logic [15:0] stat_flat
);
    // R5
    flag_follow_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req[0] |=> mode_q[2]);
    // R5
    flag_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req[1] |=> !mode_q[3]);
    // R6
    irq_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q[3] && !mode_q[5]) |-> irq_out);
    // R6
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_q[2] && !mode_q[3]) |-> !irq_out);
    // R10
    cmd_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_size == 2'd0 && acc_addr == 4'd0)
        |=> (cmd_stb[0] && cmd_byte == $past(acc_wdata[7:0])));
    // R10
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_stb));
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        err_set[0] |=> stat_flat[1]);
    // R9
    busy_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        dma_busy[1] |=> stat_flat[8]);
    // R3
    wide_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write && acc_size[1]) |=> (rdata == 32'hFFFF_FFFF));
    // R3
    wide_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_size != 2'd0) |=> $stable(mode_q[5:4]));
endmodule

bind dcbm_regs dcbm_regs_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .acc_wdata(acc_wdata),
    .irq_req  (irq_req),
    .dma_busy (dma_busy),
    .err_set  (err_set),
    .rdata    (rdata),
    .cmd_stb  (cmd_stb),
    .cmd_byte (cmd_byte),
    .irq_out  (irq_out),
    .mode_q   (mode_q),
    .stat_flat(stat_q)
);

// File: tb/dcbm_regs_bench.sv
module dcbm_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [3:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [1:0]  irq_req = '0, dma_busy = '0, err_set = '0, done_set = '0;
    logic [31:0] rdata;
    logic [1:0]  cmd_stb;
    logic [7:0]  cmd_byte;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    dcbm_regs u_dcbm_regs (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [1:0] sz = 2'd0);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_size = sz; acc_wdata = {24'hABCDEF, d};
        @(negedge clk);
        acc_valid = 0; acc_write = 0; acc_size = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [1:0] sz = 2'd0);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = sz;
        @(negedge clk);
        acc_valid = 0; acc_size = 0;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_out", {31'b0, irq_out}, 0);
        chk("R1 cmd_stb", {30'b0, cmd_stb}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(a[3:0], d);      chk("R1 ch0 reg", d, 0);
            rd(a[3:0] + 4'd8, d); chk("R1 ch1 reg", d, 0);
        end
    endtask

    task automatic t_decode();
        logic [31:0] d;
        wr(4'd0, 8'h11); wr(4'd3, 8'h22); wr(4'd8, 8'h33); wr(4'd11, 8'h44);
        rd(4'd0, d);  chk("R2 cmd0", d, 32'h11);
        rd(4'd3, d);  chk("R2 tim0", d, 32'h22);
        rd(4'd8, d);  chk("R2 cmd1", d, 32'h33);
        rd(4'd11, d); chk("R2 tim1", d, 32'h44);
        wr(4'd1, 8'h10);
        rd(4'd9, d);  chk("R2 mode at ch1 offset", d, 32'h10);
        rd(4'd1, d);  chk("R2 mode at ch0 offset", d, 32'h10);
        wr(4'd1, 8'h00);
    endtask

    task automatic t_wide();
        logic [31:0] d;
        wr(4'd3, 8'h5A);
        wr(4'd3, 8'hA5, 2'd1);
        wr(4'd1, 8'h30, 2'd2);
        wr(4'd0, 8'h77, 2'd3);
        rd(4'd3, d); chk("R3 wide write ignored (tim0)", d, 32'h5A);
        rd(4'd1, d); chk("R3 wide write ignored (mode)", d, 32'h00);
        rd(4'd0, d); chk("R3 wide write ignored (cmd0)", d, 32'h11);
        rd(4'd0, d, 2'd1); chk("R3 2-byte read", d, 32'h0000FFFF);
        rd(4'd2, d, 2'd2); chk("R3 4-byte read", d, 32'hFFFFFFFF);
    endtask

    task automatic t_mode();
        logic [31:0] d;
        wr(4'd1, 8'hFF);
        rd(4'd1, d); chk("R4 only mask bits written", d, 32'h30);
        wr(4'd9, 8'h00);
        rd(4'd1, d); chk("R4 masks cleared", d, 32'h00);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        @(negedge clk); irq_req = 2'b01;
        @(negedge clk); chk("R6 ch0 unmasked", {31'b0, irq_out}, 1);
        rd(4'd1, d); chk("R5 flag0 set", d, 32'h04);
        wr(4'd1, 8'h10); chk("R6 ch0 masked", {31'b0, irq_out}, 0);
        @(negedge clk); irq_req = 2'b11;
        @(negedge clk); chk("R6 ch1 unmasked", {31'b0, irq_out}, 1);
        wr(4'd9, 8'h30); chk("R6 both masked", {31'b0, irq_out}, 0);
        rd(4'd9, d); chk("R5 both flags with masks", d, 32'h3C);
        wr(4'd1, 8'h00); chk("R6 masks cleared", {31'b0, irq_out}, 1);
        @(negedge clk); irq_req = 2'b00;
        @(negedge clk); chk("R5 R6 requests dropped", {31'b0, irq_out}, 0);
        rd(4'd1, d); chk("R5 flags cleared", d, 32'h00);
    endtask

    task automatic t_status();
        logic [31:0] d;
        wr(4'd2, 8'hFF);
        rd(4'd2, d); chk("R7 status all-ones write", d, 32'h60);
        wr(4'd10, 8'h20);
        rd(4'd10, d); chk("R7 status ch1", d, 32'h20);
        rd(4'd2, d); chk("R7 ch0 untouched by ch1", d, 32'h60);
        wr(4'd2, 8'h00); wr(4'd10, 8'h00);
        rd(4'd2, d); chk("R7 status zero write", d, 32'h00);
    endtask

    task automatic t_w1c();
        logic [31:0] d;
        @(negedge clk); err_set = 2'b01;
        @(negedge clk); err_set = 2'b00; done_set = 2'b01;
        @(negedge clk); done_set = 2'b00;
        rd(4'd2, d); chk("R8 events set bits 1,2", d, 32'h06);
        rd(4'd10, d); chk("R8 ch1 untouched", d, 32'h00);
        wr(4'd2, 8'h02);
        rd(4'd2, d); chk("R8 W1C bit1", d, 32'h04);
        wr(4'd2, 8'h04);
        @(negedge clk); err_set = 2'b01; done_set = 2'b01;
        acc_valid = 1; acc_write = 1; acc_addr = 4'd2; acc_size = 0; acc_wdata = 32'h06;
        @(negedge clk); err_set = 0; done_set = 0; acc_valid = 0; acc_write = 0;
        rd(4'd2, d); chk("R8 set wins over clear", d, 32'h06);
        wr(4'd2, 8'h06);
        rd(4'd2, d); chk("R8 W1C both", d, 32'h00);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        @(negedge clk); dma_busy = 2'b10;
        rd(4'd10, d); chk("R9 busy mirrored", d, 32'h01);
        wr(4'd10, 8'h01);
        rd(4'd10, d); chk("R9 write keeps busy", d, 32'h01);
        rd(4'd2, d); chk("R9 ch0 not busy", d, 32'h00);
        @(negedge clk); dma_busy = 2'b00;
        rd(4'd10, d); chk("R9 busy dropped", d, 32'h00);
    endtask

    task automatic t_cmd();
        logic [31:0] d;
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = 4'd8; acc_size = 0; acc_wdata = 32'hC3;
        @(negedge clk); acc_valid = 0; acc_write = 0;
        chk("R10 strobe ch1", {30'b0, cmd_stb}, 2'b10);
        chk("R10 strobe byte", {24'b0, cmd_byte}, 32'hC3);
        @(negedge clk);
        chk("R10 strobe one cycle", {30'b0, cmd_stb}, 0);
        wr(4'd0, 8'h5C);
        rd(4'd0, d); chk("R10 cmd0 readback", d, 32'h5C);
        rd(4'd8, d); chk("R10 cmd1 readback", d, 32'hC3);
    endtask

    task automatic t_ptr();
        logic [31:0] d;
        wr(4'd4, 8'h77); wr(4'd15, 8'h88);
        rd(4'd4, d);  chk("R11 pointer byte reads zero", d, 32'h00);
        rd(4'd15, d); chk("R11 pointer byte ch1 reads zero", d, 32'h00);
        rd(4'd0, d);  chk("R11 cmd0 untouched", d, 32'h5C);
        rd(4'd11, d); chk("R11 tim1 untouched", d, 32'h44);
        chk("R11 no strobe", {30'b0, cmd_stb}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_decode();
        t_wide();
        t_mode();
        t_irq();
        t_status();
        t_w1c();
        t_busy();
        t_cmd();
        t_ptr();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule